// File: doc/BRIEF.md
# SD Single-Block Read Sequencer

This block walks an already initialised memory card through a run of 512-byte block reads, one block per command. Given a first block number, a number of blocks and a flag saying whether the card uses block addressing, it hands each single-block read command with its argument to a command engine. It then tracks the engine's events through a fixed order of waits, pulls the block out of a receive data port as 256 halfwords, and moves on to the next block number.

The halfwords leave the block as a stream, each one qualified by a one-cycle valid strobe. The run finishes with a one-cycle done pulse. A reported fault, or a wait that runs past its cycle limit, ends the run at once with a one-cycle error pulse, and the sequencer goes back to idle. Serialising the data lines and checking their CRC are left to the neighbouring blocks.

Top module: `sd_block_reader`

## Requirements
- R1: After reset the sequencer is idle: busy, cmdValid, portRead, outValid, done and error are all low.
- R2: Each block is requested with one cmdValid pulse that lasts exactly one cycle. cmdWord is 16'h1C11 while cmdValid is high: command index 17 in bits 5:0, short-response code 3'b100 in bits 10:8, the data-present flag in bit 11 and the read-direction flag in bit 12.
- R3: When highCap was high at start, cmdArg equals the block number being read.
- R4: When highCap was low at start, cmdArg equals the block number times 512, truncated to 32 bits.
- R5: Once the receive-ready event has been accepted, portRead is high for exactly 256 consecutive cycles. Every read produces an outValid pulse one cycle later, and outData carries the portData value presented in the read cycle.
- R6: Blocks are requested at consecutive block numbers, starting with startBlock, until blockCount blocks are done. The next command is issued only after the data-end event of the previous block.
- R7: done pulses for one cycle, in the cycle after the data-end event of the last block is sampled. When blockCount is zero, done pulses in the cycle after the start request and no command is issued.
- R8: evError sampled during any of the three waits (response end, receive ready, data end) raises error for one cycle in the next cycle. The sequencer then returns to idle and issues no further command.
- R9: A wait that sees neither its event nor evError within WAIT_LIMIT cycles ends the run with error. When the response never comes, error is visible WAIT_LIMIT+1 cycles after the cmdValid cycle.
- R10: startReq is ignored while a run is in progress. The run in progress keeps its block numbers and its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a run (sampled only while idle) |
| startBlock | input | 32 | First block number of the run |
| blockCount | input | 16 | Number of blocks to read |
| highCap | input | 1 | Card uses block addressing |
| busy | output | 1 | A run is in progress |
| cmdValid | output | 1 | One-cycle command request to the command engine |
| cmdWord | output | 16 | Command index, response type and data flags |
| cmdArg | output | 32 | Command argument (card address) |
| evRespEnd | input | 1 | Command response has ended |
| evRxReady | input | 1 | Receive data port holds a block |
| evDataEnd | input | 1 | Data transfer has ended |
| evError | input | 1 | Any error reported by the engine |
| portRead | output | 1 | Pops one halfword from the receive port this cycle |
| portData | input | 16 | Halfword at the head of the receive port |
| outValid | output | 1 | outData is valid this cycle |
| outData | output | 16 | Received halfword |
| done | output | 1 | One-cycle pulse: run finished |
| error | output | 1 | One-cycle pulse: run aborted |

## Verification
The read path is tried with block-addressed and byte-addressed cards. Some start blocks are large enough that the multiply by 512 overflows, which separates a correct 32-bit truncation from a wrong shift amount or a swapped mode. Runs of one, two and three blocks under different event delays show whether block numbers advance and whether the run stops exactly at the count. The data pattern mixes each word's index with its block's address, so a lost, doubled or misordered halfword shows up. A separate set of runs injects a fault or withholds the event at each of the three wait points, and one also sends a second start request in mid-run. Together they show which wait reacts, when the error pulse comes, and that nothing follows it.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_RESP,
    ST_WAIT_RX,
    ST_DRAIN,
    ST_WAIT_END
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadRun;     // capture start block, count and addressing mode
    logic advanceBlk;  // step to next block, one fewer remaining
    logic clrTimer;    // restart the wait timer
    logic clrWords;    // restart the halfword counter
    logic readPort;    // pop one halfword this cycle
  } seqStrobe_t;

  localparam logic [5:0] RD_SINGLE_IDX = 6'd17;
  localparam logic [2:0] RSP_SHORT    = 3'd4;

  function automatic logic [15:0] buildCmdWord(input logic [5:0] idx,
                                               input logic [2:0] rsp,
                                               input logic       hasData,
                                               input logic       isRead);
    return {3'b000, isRead, hasData, rsp, 2'b00, idx};
  endfunction

endpackage

// File: rtl/sdrd_datapath.sv
module sdrd_datapath
  import sdrd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 16,
  parameter int DATA_W        = 16,
  parameter int WORDS_PER_BLK = 256,
  parameter int BLK_SHIFT     = 9,
  parameter int WAIT_LIMIT    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startBlock,
  input  logic [CNT_W-1:0]  blockCount,
  input  logic              highCap,
  input  logic [DATA_W-1:0] portData,
  output logic [ADDR_W-1:0] cmdArg,
  output logic              zeroCount,
  output logic              lastBlock,
  output logic              lastWord,
  output logic              timeoutHit,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int WORD_W = $clog2(WORDS_PER_BLK);
  localparam int TMR_W  = $clog2(WAIT_LIMIT + 1);
  localparam logic [WORD_W-1:0] LAST_WORD_IDX = WORD_W'(WORDS_PER_BLK - 1);
  localparam logic [TMR_W-1:0]  LAST_WAIT_CYC = TMR_W'(WAIT_LIMIT - 1);

  logic [ADDR_W-1:0] blkNum;
  logic [CNT_W-1:0]  remain;
  logic              hcReg;
  logic [TMR_W-1:0]  timer;
  logic [WORD_W-1:0] words;

  // Run bookkeeping: block number, remaining count, addressing mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkNum <= '0;
      remain <= '0;
      hcReg  <= 1'b0;
    end else if (strobe.loadRun) begin
      blkNum <= startBlock;
      remain <= blockCount;
      hcReg  <= highCap;
    end else if (strobe.advanceBlk) begin
      blkNum <= blkNum + ADDR_W'(1);
      remain <= remain - CNT_W'(1);
    end
  end

  assign zeroCount = (blockCount == '0);
  assign lastBlock = (remain == CNT_W'(1));

  // Card address: block-addressed or byte-addressed
  logic [ADDR_W-1:0] byteAddr;
  generate
    if (BLK_SHIFT == 0) begin : g_noScale
      assign byteAddr = blkNum;
    end else begin : g_scale
      assign byteAddr = {blkNum[ADDR_W-BLK_SHIFT-1:0], {BLK_SHIFT{1'b0}}};
    end
  endgenerate

  assign cmdArg = hcReg ? blkNum : byteAddr;

  // Wait timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) begin
      timer <= '0;
    end else if (timer != '1) begin
      timer <= timer + TMR_W'(1);
    end
  end

  assign timeoutHit = (timer == LAST_WAIT_CYC);

  // Halfword counter within a block
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrWords) begin
      words <= '0;
    end else if (strobe.readPort) begin
      words <= words + WORD_W'(1);
    end
  end

  assign lastWord = (words == LAST_WORD_IDX);

  // Output register for the halfword stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.readPort;
      if (strobe.readPort) begin
        outData <= portData;
      end
    end
  end

endmodule

// File: rtl/sdrd_ctrl.sv
module sdrd_ctrl
  import sdrd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       zeroCount,
  input  logic       lastBlock,
  input  logic       lastWord,
  input  logic       timeoutHit,
  input  logic       evRespEnd,
  input  logic       evRxReady,
  input  logic       evDataEnd,
  input  logic       evError,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       cmdValid,
  output logic       done,
  output logic       error
);

  seqState_t state, nextState;
  logic      doneSet, errSet;

  always_comb begin
    strobe    = '0;
    nextState = state;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.loadRun = 1'b1;
          if (zeroCount) doneSet = 1'b1;
          else           nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strobe.clrTimer = 1'b1;
        nextState       = ST_WAIT_RESP;
      end
      ST_WAIT_RESP: begin
        if (evError) begin
          errSet = 1'b1;  nextState = ST_IDLE;
        end else if (evRespEnd) begin
          strobe.clrTimer = 1'b1;  nextState = ST_WAIT_RX;
        end else if (timeoutHit) begin
          errSet = 1'b1;  nextState = ST_IDLE;
        end
      end
      ST_WAIT_RX: begin
        if (evError) begin
          errSet = 1'b1;  nextState = ST_IDLE;
        end else if (evRxReady) begin
          strobe.clrWords = 1'b1;  nextState = ST_DRAIN;
        end else if (timeoutHit) begin
          errSet = 1'b1;  nextState = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        strobe.readPort = 1'b1;
        if (lastWord) begin
          strobe.clrTimer = 1'b1;  nextState = ST_WAIT_END;
        end
      end
      ST_WAIT_END: begin
        if (evError) begin
          errSet = 1'b1;  nextState = ST_IDLE;
        end else if (evDataEnd) begin
          if (lastBlock) begin
            doneSet = 1'b1;  nextState = ST_IDLE;
          end else begin
            strobe.advanceBlk = 1'b1;  nextState = ST_ISSUE;
          end
        end else if (timeoutHit) begin
          errSet = 1'b1;  nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneSet;
      error <= errSet;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign cmdValid = (state == ST_ISSUE);

endmodule

// File: rtl/sd_block_reader.sv
module sd_block_reader
  import sdrd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 16,
  parameter int DATA_W        = 16,
  parameter int WORDS_PER_BLK = 256,
  parameter int BLK_SHIFT     = 9,
  parameter int WAIT_LIMIT    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startBlock,
  input  logic [CNT_W-1:0]  blockCount,
  input  logic              highCap,
  output logic              busy,
  output logic              cmdValid,
  output logic [15:0]       cmdWord,
  output logic [ADDR_W-1:0] cmdArg,
  input  logic              evRespEnd,
  input  logic              evRxReady,
  input  logic              evDataEnd,
  input  logic              evError,
  output logic              portRead,
  input  logic [DATA_W-1:0] portData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              done,
  output logic              error
);

  seqStrobe_t strobe;
  logic       zeroCount, lastBlock, lastWord, timeoutHit;

  sdrd_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .zeroCount  (zeroCount),
    .lastBlock  (lastBlock),
    .lastWord   (lastWord),
    .timeoutHit (timeoutHit),
    .evRespEnd  (evRespEnd),
    .evRxReady  (evRxReady),
    .evDataEnd  (evDataEnd),
    .evError    (evError),
    .strobe     (strobe),
    .busy       (busy),
    .cmdValid   (cmdValid),
    .done       (done),
    .error      (error)
  );

  sdrd_datapath #(
    .ADDR_W        (ADDR_W),
    .CNT_W         (CNT_W),
    .DATA_W        (DATA_W),
    .WORDS_PER_BLK (WORDS_PER_BLK),
    .BLK_SHIFT     (BLK_SHIFT),
    .WAIT_LIMIT    (WAIT_LIMIT)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startBlock (startBlock),
    .blockCount (blockCount),
    .highCap    (highCap),
    .portData   (portData),
    .cmdArg     (cmdArg),
    .zeroCount  (zeroCount),
    .lastBlock  (lastBlock),
    .lastWord   (lastWord),
    .timeoutHit (timeoutHit),
    .outValid   (outValid),
    .outData    (outData)
  );

  assign portRead = strobe.readPort;
  assign cmdWord  = buildCmdWord(RD_SINGLE_IDX, RSP_SHORT, 1'b1, 1'b1);

endmodule

// File: rtl/sd_block_reader_chk.sv
module sd_block_reader_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic busy,
  input logic cmdValid,
  input logic evDataEnd,
  input logic portRead,
  input logic outValid,
  input logic done,
  input logic error
);

  assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_cmd_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

  assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(portRead));

  assert_read_in_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    portRead |-> busy);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(evDataEnd) || $past(startReq)));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !error));

  assert_error_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !busy);

endmodule

bind sd_block_reader sd_block_reader_chk i_chk (.*);

// File: tb/test_sd_block_reader.sv
module test_sd_block_reader;

  localparam int WL   = 64;
  localparam int NBLK = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] startBlock = '0;
  logic [15:0] blockCount = '0;
  logic        highCap = 1'b0;
  logic        busy, cmdValid, portRead, outValid, done, error;
  logic [15:0] cmdWord, outData;
  logic [31:0] cmdArg;
  logic        evRespEnd = 1'b0, evRxReady = 1'b0, evDataEnd = 1'b0, evError = 1'b0;
  logic [15:0] portData = '0;

  always #5 clk = ~clk;

  sd_block_reader #(.WAIT_LIMIT(WL)) i_sd_block_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startBlock(startBlock),
    .blockCount(blockCount), .highCap(highCap), .busy(busy), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .cmdArg(cmdArg), .evRespEnd(evRespEnd), .evRxReady(evRxReady),
    .evDataEnd(evDataEnd), .evError(evError), .portRead(portRead), .portData(portData),
    .outValid(outValid), .outData(outData), .done(done), .error(error)
  );

  int nChk = 0, nFail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [31:0] a, input int i);
    return {a[7:0] ^ 8'h5A, 8'(i)};
  endfunction

  // Card / engine model knobs
  int kResp = 1, kRx = 1, kEnd = 1, kErrStage = 0, kSilentStage = 0;
  logic [31:0] expBlk = '0;
  logic        expHc = 1'b0;
  // Observation
  int nCmd = 0, nWords = 0, dataErrs = 0, argErrs = 0, wordErrs = 0;
  int doneCnt = 0, errCnt = 0;
  longint cyc = 0, cmdCyc = 0, errCyc = 0, doneCyc = 0, endCyc = 0;
  logic [31:0] curArg = '0;
  int chkIdx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Engine model and output monitor, all at the falling edge
  initial begin
    int phase = 0, cnt = 0, words = 0;
    forever begin
      @(negedge clk);
      evRespEnd = 1'b0; evRxReady = 1'b0; evDataEnd = 1'b0; evError = 1'b0;
      if (!rstN) begin
        phase = 0;
      end else begin
        if (done)  begin doneCnt++; doneCyc = cyc; end
        if (error) begin errCnt++;  errCyc = cyc;  end
        if (outValid) begin
          if (outData !== pat(curArg, chkIdx)) dataErrs++;
          chkIdx++; nWords++;
        end
        case (phase)
          0: if (cmdValid) begin
               nCmd++; cmdCyc = cyc; curArg = cmdArg; chkIdx = 0;
               if (cmdWord !== 16'h1C11) wordErrs++;
               if (cmdArg !== (expHc ? expBlk : (expBlk << 9))) argErrs++;
               expBlk = expBlk + 1;
               cnt = kResp; phase = 1;
             end
          1: begin
               cnt--;
               if (cnt == 0) begin
                 if (kErrStage == 1) begin evError = 1'b1; phase = 0; end
                 else if (kSilentStage == 1) phase = 0;
                 else begin evRespEnd = 1'b1; cnt = kRx; phase = 2; end
               end
             end
          2: begin
               cnt--;
               if (cnt == 0) begin
                 if (kErrStage == 2) begin evError = 1'b1; phase = 0; end
                 else if (kSilentStage == 2) phase = 0;
                 else begin evRxReady = 1'b1; words = 0; phase = 3; end
               end
             end
          3: if (portRead) begin
               portData = pat(curArg, words);
               words++;
               if (words == NBLK) begin cnt = kEnd; phase = 4; end
             end
          default: begin
               cnt--;
               if (cnt == 0) begin
                 if (kErrStage == 3) evError = 1'b1;
                 else if (kSilentStage != 3) begin evDataEnd = 1'b1; endCyc = cyc; end
                 phase = 0;
               end
             end
        endcase
      end
    end
  end

  task automatic startRun(input logic [31:0] blk, input logic [15:0] cntIn, input logic hc);
    expBlk = blk; expHc = hc;
    nCmd = 0; nWords = 0; dataErrs = 0; argErrs = 0; wordErrs = 0;
    doneCnt = 0; errCnt = 0;
    @(negedge clk);
    startBlock = blk; blockCount = cntIn; highCap = hc; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitEnd();
    for (int g = 0; g < 5000 && doneCnt == 0 && errCnt == 0; g++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic goodRun(input logic [31:0] blk, input logic [15:0] cntIn, input logic hc,
                         input int dr, input int dx, input int de);
    kResp = dr; kRx = dx; kEnd = de; kErrStage = 0; kSilentStage = 0;
    startRun(blk, cntIn, hc);
    waitEnd();
    check(argErrs == 0, hc ? "R3 argument" : "R4 argument", argErrs, 0);
    check(wordErrs == 0, "R2 command word", wordErrs, 0);
    check(nCmd == int'(cntIn), "R6 command count", nCmd, cntIn);
    check(nWords == NBLK * int'(cntIn), "R5 halfword count", nWords, NBLK * cntIn);
    check(dataErrs == 0, "R5 halfword data", dataErrs, 0);
    check(doneCnt == 1 && errCnt == 0, "R7 single done", doneCnt, 1);
    check(doneCyc == endCyc + 1, "R7 done timing", doneCyc - endCyc, 1);
  endtask

  typedef struct packed {
    logic [31:0] blk;
    logic [15:0] cnt;
    logic        hc;
    logic [7:0]  dResp;
    logic [7:0]  dRx;
    logic [7:0]  dEnd;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{blk: 32'd5,          cnt: 16'd1, hc: 1'b1, dResp: 8'd1, dRx: 8'd1, dEnd: 8'd1},
    '{blk: 32'd7,          cnt: 16'd2, hc: 1'b0, dResp: 8'd3, dRx: 8'd2, dEnd: 8'd1},
    '{blk: 32'h00FF_FFFE,  cnt: 16'd3, hc: 1'b1, dResp: 8'd1, dRx: 8'd4, dEnd: 8'd2},
    '{blk: 32'h0080_0001,  cnt: 16'd1, hc: 1'b0, dResp: 8'd2, dRx: 8'd1, dEnd: 8'd3},
    '{blk: 32'h0000_0000,  cnt: 16'd2, hc: 1'b0, dResp: 8'd60, dRx: 8'd64, dEnd: 8'd5}
  };

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && cmdValid == 0 && portRead == 0, "R1 idle in reset", {busy, cmdValid, portRead}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && outValid == 0 && done == 0 && error == 0, "R1 idle after reset",
          {busy, outValid, done, error}, 0);

    // Table of good runs (R2..R7); last entry uses waits at the limit edge
    foreach (VECS[i]) begin
      goodRun(VECS[i].blk, VECS[i].cnt, VECS[i].hc,
              int'(VECS[i].dResp), int'(VECS[i].dRx), int'(VECS[i].dEnd));
    end

    // R7: zero count
    kErrStage = 0; kSilentStage = 0;
    startRun(32'd9, 16'd0, 1'b1);
    repeat (10) @(negedge clk);
    check(doneCnt == 1 && nCmd == 0, "R7 zero count", {doneCnt, nCmd}, 32'h1_0);

    // R8: fault at each wait point
    for (int s = 1; s <= 3; s++) begin
      kResp = 1; kRx = 1; kEnd = 1; kErrStage = s; kSilentStage = 0;
      startRun(32'd40, 16'd3, 1'b1);
      waitEnd();
      check(errCnt == 1 && doneCnt == 0, "R8 error pulse", errCnt, 1);
      check(nCmd == 1, "R8 no further command", nCmd, 1);
      if (s == 1) check(errCyc == cmdCyc + 2, "R8 error timing", errCyc - cmdCyc, 2);
    end

    // R9: timeout at response wait and at data-end wait
    kErrStage = 0; kSilentStage = 1;
    startRun(32'd12, 16'd2, 1'b0);
    waitEnd();
    check(errCnt == 1 && nCmd == 1, "R9 response timeout", errCnt, 1);
    check(errCyc == cmdCyc + WL + 1, "R9 timeout timing", errCyc - cmdCyc, WL + 1);
    kSilentStage = 3;
    startRun(32'd12, 16'd2, 1'b0);
    waitEnd();
    check(errCnt == 1 && nCmd == 1 && doneCnt == 0, "R9 data-end timeout", errCnt, 1);

    // R10: start while busy is ignored
    kSilentStage = 0; kResp = 2; kRx = 2; kEnd = 2;
    startRun(32'd100, 16'd2, 1'b1);
    repeat (30) @(negedge clk);
    startBlock = 32'd999; blockCount = 16'd5; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitEnd();
    check(nCmd == 2 && argErrs == 0 && doneCnt == 1, "R10 start ignored while busy", nCmd, 2);

    $display("Result: errors=%0d of %0d checks", nFail, nChk);
    $finish;
  end

endmodule